// File: doc/BRIEF.md
# Vertical Sweep Burst Generator

This block drives the four logic-level vertical transfer controls of an interline image sensor during a fast row dump. When a sweep request arrives at a line boundary, the block waits a fixed lead-in of clocks and then runs a burst of four-phase transfers. Each transfer is four overlapping phase steps. The burst can span many lines, and during it the normal line pattern is ignored. A whole-array flush uses long steps and a count near the full row total, for example 28 clocks per step and 1739 transfers. A crop sweep above or below a focus window uses 8-clock steps and a few hundred transfers.

The step length and the transfer count are sampled when the request is accepted. The block raises a one-clock completion strobe after the last step has been held for its full length. Between bursts the phases rest at their hold state. Level shifting and normal-rate transfer timing are handled elsewhere.

Top module: `vsweep_burst`

## Requirements
- R1: After reset, `vPhase` is 4'b0011 (bit 0 is V1, bit 3 is V4), and `busy` and `done` are low.
- R2: A request seen while idle is accepted at that clock edge. `busy` is high from the next cycle. The first phase change happens exactly LEAD_CLKS edges after the accepting edge (default 60).
- R3: Each phase change moves to the next pattern in this cycle: 0011, 0110, 1100, 1001, and back to 0011. One pass through the four patterns is one transfer.
- R4: Every step holds for `stepClocks` cycles. A `stepClocks` value of 0 is treated as 1.
- R5: A burst makes exactly 4 × `transferCount` phase changes and ends with the pattern back at 0011.
- R6: `done` is high for exactly one cycle, at edge LEAD_CLKS + 4·N·P after the accepting edge (N is the transfer count, P is the effective step length). `busy` is low from that same cycle.
- R7: While `busy` is high, a new request and any change on `stepClocks` or `transferCount` have no effect on the burst timing or on the phase pattern.
- R8: With a transfer count of 0, the phases never move, and `done` comes LEAD_CLKS edges after the accepting edge.
- R9: At every cycle exactly two phases are high, and V1/V3 and V2/V4 are never high together.
- R10: While `busy` is low, `vPhase` stays at the hold pattern 0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sweepReq | input | 1 | Sweep request, asserted at a line boundary |
| stepClocks | input | STEP_W | Clocks per phase step, sampled when the request is accepted |
| transferCount | input | CNT_W | Row transfers in the burst, sampled when the request is accepted |
| vPhase | output | 4 | Vertical phase controls, bit 0 = V1 through bit 3 = V4 |
| busy | output | 1 | High from the accept until the burst completes |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach from the ports is a request, or a change in the programmed values, that arrives in the middle of a burst. If that stimulus were not ignored, it would only show as a shifted step boundary or a changed step count many cycles later. The bench therefore re-drives the request with altered step length and count, once during the lead-in and once just after the first step. It then compares every cycle of `vPhase`, `busy` and `done` against a timeline computed from the original values. It also sweeps every step length from 0 to 4 against every count from 0 to 3, so that the zero-count and zero-step corners and the wrap from the last pattern back to hold are all reached.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2
  } sweepState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // capture transfer count, clear step position
    logic advance;  // move to next phase step
  } sweepStrobe_t;
endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int LEAD_CLKS = 60,
  parameter int STEP_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sweepReq,
  input  logic [STEP_W-1:0] stepClocks,
  input  logic              stepsDone,
  output sweepStrobe_t      strobe,
  output logic              busy,
  output logic              done
);
  localparam int LEAD_W = $clog2(LEAD_CLKS + 1);

  sweepState_t       state;
  logic [LEAD_W-1:0] leadCnt;
  logic [STEP_W-1:0] stepTimer;
  logic [STEP_W-1:0] period;
  logic              accept, leadEnd, stepEnd, boundary, finish;

  always_comb begin
    accept   = (state == ST_IDLE) && sweepReq;
    leadEnd  = (state == ST_LEAD) && (leadCnt == LEAD_W'(LEAD_CLKS - 1));
    stepEnd  = (state == ST_RUN) && (stepTimer == period - 1'b1);
    boundary = leadEnd || stepEnd;
    finish   = boundary && stepsDone;
    strobe.load    = accept;
    strobe.advance = boundary && !stepsDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      leadCnt   <= '0;
      stepTimer <= '0;
      period    <= STEP_W'(1);
      done      <= 1'b0;
    end else begin
      done <= finish;
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_LEAD;
          leadCnt <= '0;
          period  <= (stepClocks == '0) ? STEP_W'(1) : stepClocks;
        end
        ST_LEAD: begin
          leadCnt <= leadCnt + 1'b1;
          if (leadEnd) begin
            state     <= finish ? ST_IDLE : ST_RUN;
            stepTimer <= '0;
          end
        end
        ST_RUN: begin
          stepTimer <= stepTimer + 1'b1;
          if (stepEnd) begin
            stepTimer <= '0;
            if (finish) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sweep_phase.sv
module sweep_phase
  import sweep_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  sweepStrobe_t     strobe,
  input  logic [CNT_W-1:0] transferCount,
  output logic [3:0]       vPhase,
  output logic             stepsDone
);
  localparam int LEFT_W = CNT_W + 2;

  logic [LEFT_W-1:0] stepsLeft;
  logic [1:0]        stepIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepsLeft <= '0;
      stepIdx   <= '0;
    end else if (strobe.load) begin
      stepsLeft <= {transferCount, 2'b00};
      stepIdx   <= '0;
    end else if (strobe.advance) begin
      stepsLeft <= stepsLeft - 1'b1;
      stepIdx   <= stepIdx + 1'b1;
    end
  end

  assign stepsDone = (stepsLeft == '0);

  // phase i is high on step i and on step i-1 (mod 4)
  for (genvar i = 0; i < 4; i++) begin : g_phase
    assign vPhase[i] = (stepIdx == 2'(i)) || (stepIdx == 2'(i + 3));
  end
endmodule

// File: rtl/vsweep_burst.sv
module vsweep_burst
  import sweep_pkg::*;
#(
  parameter int LEAD_CLKS = 60,
  parameter int STEP_W    = 6,
  parameter int CNT_W     = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sweepReq,
  input  logic [STEP_W-1:0] stepClocks,
  input  logic [CNT_W-1:0]  transferCount,
  output logic [3:0]        vPhase,
  output logic              busy,
  output logic              done
);
  sweepStrobe_t strobe;
  logic         stepsDone;

  sweep_ctrl #(.LEAD_CLKS(LEAD_CLKS), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sweepReq(sweepReq), .stepClocks(stepClocks),
    .stepsDone(stepsDone), .strobe(strobe), .busy(busy), .done(done)
  );

  sweep_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rstN(rstN), .strobe(strobe), .transferCount(transferCount),
    .vPhase(vPhase), .stepsDone(stepsDone)
  );
endmodule

// File: rtl/vsweep_burst_chk.sv
module vsweep_burst_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] vPhase,
  input logic       busy,
  input logic       done
);
  AST_TWO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $countones(vPhase) == 2); // R9
  AST_NO_OPPOSITE: assert property (@(posedge clk) disable iff (!rstN)
    !(vPhase[0] && vPhase[2]) && !(vPhase[1] && vPhase[3])); // R9
  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vPhase) |-> vPhase == {$past(vPhase[2:0]), $past(vPhase[3])}); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> vPhase == 4'b0011); // R10
  AST_MOVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vPhase) |-> busy); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R6
  AST_FALL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R6
endmodule

bind vsweep_burst vsweep_burst_chk u_chk (
  .clk(clk), .rstN(rstN), .vPhase(vPhase), .busy(busy), .done(done)
);

// File: tb/vsweep_burst_tb.sv
module vsweep_burst_tb;
  localparam int LEAD = 60;
  localparam int SW   = 6;
  localparam int CW   = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sweepReq = 1'b0;
  logic [SW-1:0] stepClocks = '0;
  logic [CW-1:0] transferCount = '0;
  logic [3:0]    vPhase;
  logic          busy, done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  vsweep_burst #(.LEAD_CLKS(LEAD), .STEP_W(SW), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .sweepReq(sweepReq), .stepClocks(stepClocks),
    .transferCount(transferCount), .vPhase(vPhase), .busy(busy), .done(done)
  );

  function automatic logic [3:0] patOf(int idx);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (((i - idx) & 3) <= 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // disturb: 0 none, 1 during lead-in, 2 just after first step
  task automatic runBurst(input int p, input int n, input int disturb);
    int pe, total, dk, s;
    bit phOk, bzOk, dnOk;
    int phAct, phExp, bzAct, bzExp, dnAct, dnExp;
    pe = (p == 0) ? 1 : p;
    total = LEAD + 4 * n * pe;
    dk = (disturb == 1) ? 3 : LEAD + 1;
    phOk = 1; bzOk = 1; dnOk = 1;
    phAct = 0; phExp = 0; bzAct = 0; bzExp = 0; dnAct = 0; dnExp = 0;
    @(negedge clk);
    sweepReq = 1'b1; stepClocks = SW'(p); transferCount = CW'(n);
    @(negedge clk);
    sweepReq = 1'b0;
    for (int k = 0; k <= total + 2; k++) begin
      logic [3:0] ep;
      if (k < LEAD || n == 0) ep = patOf(0);
      else begin
        s = (k - LEAD) / pe + 1;
        if (s > 4 * n) s = 4 * n;
        ep = patOf(s % 4);
      end
      if (phOk && vPhase !== ep) begin phOk = 0; phAct = vPhase; phExp = ep; end
      if (bzOk && busy !== (k < total)) begin bzOk = 0; bzAct = busy; bzExp = (k < total); end
      if (dnOk && done !== (k == total)) begin dnOk = 0; dnAct = done; dnExp = (k == total); end
      if (disturb != 0 && k == dk && k < total) begin
        sweepReq = 1'b1; stepClocks = SW'(pe + 3); transferCount = CW'(n + 2);
      end else if (disturb != 0 && k == dk + 1) begin
        sweepReq = 1'b0; stepClocks = SW'(p); transferCount = CW'(n);
      end
      @(negedge clk);
    end
    sweepReq = 1'b0;
    check(phOk, (n == 0) ? "R8" : "R3/R4/R5", $sformatf("phase p=%0d n=%0d", p, n), phAct, phExp);
    check(bzOk, "R2", $sformatf("busy p=%0d n=%0d", p, n), bzAct, bzExp);
    check(dnOk, "R6", $sformatf("done p=%0d n=%0d", p, n), dnAct, dnExp);
    if (disturb != 0)
      check(phOk && bzOk && dnOk, "R7", $sformatf("mid-burst request ignored mode=%0d", disturb), 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(vPhase === 4'b0011, "R1", "reset phase", vPhase, 3);
    check(busy === 1'b0 && done === 1'b0, "R1", "reset busy/done", {busy, done}, 0);
    // R10: no request, phases hold
    repeat (5) @(negedge clk);
    check(vPhase === 4'b0011 && !busy, "R10", "idle hold", vPhase, 3);
    for (int p = 0; p <= 4; p++)
      for (int n = 0; n <= 3; n++)
        runBurst(p, n, 0);
    runBurst(28, 5, 0);       // full-sweep style step length
    runBurst(8, 3, 1);        // R7 request during lead-in
    runBurst(8, 3, 2);        // R7 request during stepping
    repeat (4) @(negedge clk);
    check(vPhase === 4'b0011 && !busy && !done, "R10", "idle after bursts", vPhase, 3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule